// File: doc/BRIEF.md
# Cascaded-Subfilter Programmable Low-Pass FIR

This block filters a stream of signed samples with a low-pass response chosen at run time. It has no single long delay line. Each sample travels through a chain of nine identical short subfilters. All nine have the same fixed, symmetric, linear-phase coefficients. The output of every stage is weighted by a tap weight, and the weighted outputs are summed. The result is rounded and saturated to produce the output sample. Selecting a different response changes only the nine tap weights, taken from an internal constant table. The subfilter coefficients and the stored history are never touched.

All stages update in parallel on each accepted sample, so adding stages costs no throughput. Samples arrive with a valid strobe and may be spaced by any number of idle cycles. Each result appears a fixed number of cycles after its sample, marked by its own valid strobe.

Top module: `cascade_fir`

## Requirements
- R1: A synchronous active-high reset clears all subfilter history, every stage output, the tap weights and the valid pipeline. After reset `out_valid` is 0 and `out_sample` is 0, and the first results are computed as if every earlier sample had been zero.
- R2: `out_valid` is high exactly three clock cycles after a cycle in which `in_valid` was high, and low otherwise. `out_sample` changes only when `out_valid` is high, and holds its value in all other cycles.
- R3: Each stage is a 5-tap symmetric subfilter with coefficients (-6, 20, 36, 20, -6). The two outer pairs are pre-added. On each accepted sample the stage computes the weighted sum of its new input and its four previous inputs, then divides by 64 rounding toward minus infinity (an arithmetic shift by 6), at a stage width of input width plus 5 bits. Stage 0 takes the input sample. Stage k (k ≥ 1) takes the output that stage k-1 held before this sample.
- R4: The result is S = sum over k of w[c][k]·y[k], where y[k] are the stage outputs just updated for the sample and c is the select code presented with that sample. The output is floor((S + 4) / 8), saturated as in R8.
- R5: Code 0 gives weight 8 on the last stage (index 8) and 0 on all others, so the output equals the ninth stage output. A code c from 1 to 55 gives weight w[c][k] = ((c + 7k) mod 64) − 16 for stage k = 0..8.
- R6: Codes 56 to 63 produce the same weights as code 0.
- R7: The select code is sampled only together with an accepted sample and applies to that sample's result. Changing it between samples leaves the subfilter history intact.
- R8: Results above 32767 are output as 32767. Results below −32768 are output as −32768.
- R9: In cycles with `in_valid` low, `in_sample` and `sel` are ignored, and no stage history or stage output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `in_sample` and `sel` this cycle |
| in_sample | input | 12 | Signed input sample |
| sel | input | 6 | Response select code |
| out_valid | output | 1 | `out_sample` holds a new result |
| out_sample | output | 16 | Signed rounded and saturated result |

## Verification
The bench builds the block with its default parameters: a 12-bit input, nine stages, a 56-entry weight table, 8-bit weights scaled by 8 and a 16-bit output. With the result scaled down by only 3 bits, a full-scale constant input on a code whose weights sum past 128 drives the output into both saturation limits. Runs against a sample-by-sample model cover an impulse through the long default response, mid-stream code switches including codes in the default range, and sparse valid patterns with changing data and codes in the idle cycles.

// File: rtl/cfir_pkg.sv
package cfir_pkg;
  // Fixed symmetric subfilter coefficients (outer, inner, centre) and gain shift
  localparam int SUB_CW = 8;
  localparam logic signed [SUB_CW-1:0] SUB_C0 = -8'sd6;
  localparam logic signed [SUB_CW-1:0] SUB_C1 = 8'sd20;
  localparam logic signed [SUB_CW-1:0] SUB_C2 = 8'sd36;
  localparam int SUB_SH = 6;

  // Tap weight for response code and stage index; out-of-table codes fall back to code 0
  function automatic int tap_weight(input int code, input int k, input int nstg,
                                    input int nresp, input int rs);
    if (code == 0 || code >= nresp)
      return (k == nstg - 1) ? (1 << rs) : 0;
    return ((code + 7 * k) % 64) - 16;
  endfunction
endpackage

// File: rtl/cfir_stage.sv
module cfir_stage #(
  parameter int SW = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic signed [SW-1:0] din,
  output logic signed [SW-1:0] dout
);
  localparam int NDLY = 4;
  localparam int MW   = SW + cfir_pkg::SUB_CW + 4;

  logic signed [SW-1:0] dly [NDLY];
  logic signed [MW-1:0] pair_out, pair_in, acc;

  always_comb begin
    pair_out = MW'(din) + MW'(dly[3]);
    pair_in  = MW'(dly[0]) + MW'(dly[2]);
    acc = pair_out * MW'(cfir_pkg::SUB_C0)
        + pair_in  * MW'(cfir_pkg::SUB_C1)
        + MW'(dly[1]) * MW'(cfir_pkg::SUB_C2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDLY; i++) dly[i] <= '0;
      dout <= '0;
    end else if (adv) begin
      dly[0] <= din;
      for (int i = 1; i < NDLY; i++) dly[i] <= dly[i-1];
      dout <= SW'(acc >>> cfir_pkg::SUB_SH);
    end
  end
endmodule

// File: rtl/cfir_taps.sv
module cfir_taps #(
  parameter int NSTG = 9,
  parameter int SW   = 17,
  parameter int TW   = 8,
  parameter int RS   = 3,
  parameter int OW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [TW-1:0] wgt [NSTG],
  input  logic signed [SW-1:0] ystg [NSTG],
  output logic                 out_valid,
  output logic signed [OW-1:0] out_sample
);
  localparam int PW = TW + SW;
  localparam int AW = PW + $clog2(NSTG) + 1;
  localparam logic signed [AW-1:0] OMAX = AW'((1 << (OW - 1)) - 1);
  localparam logic signed [AW-1:0] OMIN = -OMAX - AW'(1);
  localparam logic signed [AW-1:0] HALF = AW'(1 << (RS - 1));

  logic signed [PW-1:0] prod [NSTG];
  logic                 v_sum;
  logic signed [AW-1:0] total, scaled;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_sum <= 1'b0;
      for (int k = 0; k < NSTG; k++) prod[k] <= '0;
    end else begin
      v_sum <= v_in;
      if (v_in)
        for (int k = 0; k < NSTG; k++) prod[k] <= PW'(wgt[k]) * PW'(ystg[k]);
    end
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < NSTG; k++) total = total + AW'(prod[k]);
    scaled = (total + HALF) >>> RS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= v_sum;
      if (v_sum) begin
        if (scaled > OMAX)      out_sample <= OW'(OMAX);
        else if (scaled < OMIN) out_sample <= OW'(OMIN);
        else                    out_sample <= OW'(scaled);
      end
    end
  end
endmodule

// File: rtl/cascade_fir.sv
module cascade_fir #(
  parameter int DW    = 12,
  parameter int GROW  = 5,
  parameter int NSTG  = 9,
  parameter int SELW  = 6,
  parameter int NRESP = 56,
  parameter int TW    = 8,
  parameter int RS    = 3,
  parameter int OW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic [SELW-1:0]      sel,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_sample
);
  localparam int SW = DW + GROW;

  logic signed [SW-1:0] y_tap [NSTG];
  logic signed [TW-1:0] w_q   [NSTG];
  logic                 v_stg;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    logic signed [SW-1:0] feed;
    if (k == 0) begin : g_head
      assign feed = SW'(in_sample);
    end else begin : g_link
      assign feed = y_tap[k-1];
    end
    cfir_stage #(.SW(SW)) u_stage (
      .clk (clk),
      .rst (rst),
      .adv (in_valid),
      .din (feed),
      .dout(y_tap[k])
    );
  end

  // Weight ROM read, registered together with the accepted sample
  always_ff @(posedge clk) begin
    if (rst) begin
      v_stg <= 1'b0;
      for (int k = 0; k < NSTG; k++) w_q[k] <= '0;
    end else begin
      v_stg <= in_valid;
      if (in_valid)
        for (int k = 0; k < NSTG; k++)
          w_q[k] <= TW'(cfir_pkg::tap_weight(int'(sel), k, NSTG, NRESP, RS));
    end
  end

  cfir_taps #(.NSTG(NSTG), .SW(SW), .TW(TW), .RS(RS), .OW(OW)) u_taps (
    .clk       (clk),
    .rst       (rst),
    .v_in      (v_stg),
    .wgt       (w_q),
    .ystg      (y_tap),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );
endmodule

// File: rtl/cascade_fir_chk.sv
module cascade_fir_chk #(
  parameter int SW = 17,
  parameter int OW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_sample,
  input logic signed [SW-1:0] tail
);
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_sample == '0));

  // R2
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R2
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (seen != 2'd0 && !out_valid) |-> $stable(out_sample));

  // R9
  a_r9_stall_keeps_stage: assert property (@(posedge clk) disable iff (rst)
    (seen != 2'd0 && !in_valid) |=> $stable(tail));
endmodule

bind cascade_fir cascade_fir_chk #(.SW(SW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sample(out_sample),
  .tail      (y_tap[NSTG-1])
);

// File: tb/cascade_fir_test.sv
`timescale 1ns/1ps
module cascade_fir_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [11:0] in_sample = '0;
  logic [5:0] sel = '0;
  logic out_valid;
  logic signed [15:0] out_sample;

  always #2 clk = ~clk;

  cascade_fir uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .sel(sel), .out_valid(out_valid), .out_sample(out_sample)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bit     vv [256];
  int     xv [256];
  int     cv [256];
  longint ev [256];
  longint hist [9][4];
  longint yr [9];
  longint held;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint wtab(input int c, input int k);
    if (c == 0 || c >= 56) return (k == 8) ? 8 : 0;
    return ((c + 7 * k) % 64) - 16;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 9; k++) begin
      yr[k] = 0;
      for (int i = 0; i < 4; i++) hist[k][i] = 0;
    end
    held = 0;
  endtask

  task automatic model_step(input int x, input int c, output longint res);
    longint s, u, r;
    for (int k = 8; k >= 0; k--) begin
      u = (k == 0) ? longint'(x) : yr[k-1];
      s = -6 * (u + hist[k][3]) + 20 * (hist[k][0] + hist[k][2]) + 36 * hist[k][1];
      hist[k][3] = hist[k][2];
      hist[k][2] = hist[k][1];
      hist[k][1] = hist[k][0];
      hist[k][0] = u;
      yr[k] = s >>> 6;
    end
    s = 0;
    for (int k = 0; k < 9; k++) s += wtab(c, k) * yr[k];
    r = (s + 4) >>> 3;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    res = r;
  endtask

  task automatic run_seq(input int n, input string req);
    for (int m = 0; m < n + 3; m++) begin
      @(negedge clk);
      if (m >= 3) begin
        check(out_valid == vv[m-3], req, "out_valid", longint'(out_valid), longint'(vv[m-3]));
        if (vv[m-3]) held = ev[m-3];
        check(longint'(out_sample) == held, req, "out_sample", longint'(out_sample), held);
      end
      if (m < n) begin
        in_valid  = vv[m];
        in_sample = 12'(xv[m]);
        sel       = 6'(cv[m]);
        if (vv[m]) model_step(xv[m], cv[m], ev[m]);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    check(out_valid == 1'b0, req, "reset out_valid", longint'(out_valid), 0);
    check(out_sample == '0, req, "reset out_sample", longint'(out_sample), 0);
  endtask

  // R1: reset state
  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "initial out_valid", longint'(out_valid), 0);
    check(out_sample == '0, "R1", "initial out_sample", longint'(out_sample), 0);
  endtask

  // R3, R5: impulse through the default (code 0) response
  task automatic t_impulse();
    for (int i = 0; i < 60; i++) begin
      vv[i] = 1'b1; xv[i] = (i == 0) ? 1500 : 0; cv[i] = 0;
    end
    run_seq(60, "R3");
  endtask

  // R4, R5: steps and ramps under table codes
  task automatic t_codes();
    for (int i = 0; i < 50; i++) begin
      vv[i] = 1'b1; xv[i] = (i < 25) ? 700 : -300 + 17 * i; cv[i] = 5;
    end
    run_seq(50, "R4");
    for (int i = 0; i < 50; i++) begin
      vv[i] = 1'b1; xv[i] = ((i * 37) % 200) - 100; cv[i] = 37;
    end
    run_seq(50, "R5");
  endtask

  // R6: codes beyond the table act as code 0
  task automatic t_default_codes();
    for (int i = 0; i < 40; i++) begin
      vv[i] = 1'b1; xv[i] = (i % 7 == 0) ? 900 : -50; cv[i] = 56 + (i % 8);
    end
    run_seq(40, "R6");
  endtask

  // R7: code changes between samples, history retained
  task automatic t_sel_switch();
    for (int i = 0; i < 48; i++) begin
      vv[i] = 1'b1; xv[i] = (i < 12) ? 1200 : ((i % 3) * 400 - 400);
      cv[i] = (i % 4 == 0) ? 3 : (i % 4 == 1) ? 17 : (i % 4 == 2) ? 60 : 0;
    end
    run_seq(48, "R7");
  endtask

  // R9, R2: idle cycles with changing data and codes
  task automatic t_gaps();
    for (int i = 0; i < 80; i++) begin
      vv[i] = (i % 3 == 0) || (i % 5 == 1);
      xv[i] = vv[i] ? ((i * 53) % 900) - 450 : 2047 - i;
      cv[i] = vv[i] ? 22 : 63 - (i % 50);
    end
    run_seq(80, "R9");
  endtask

  // R8: saturation at both limits with code 40 (weight sum 148)
  task automatic t_saturate();
    for (int i = 0; i < 120; i++) begin
      vv[i] = 1'b1; xv[i] = (i < 60) ? 2047 : -2048; cv[i] = 40;
    end
    run_seq(120, "R8");
    check(out_sample == -16'sd32768, "R8", "low limit", longint'(out_sample), -32768);
  endtask

  // R1: reset in mid-stream drops history
  task automatic t_reset_mid();
    for (int i = 0; i < 20; i++) begin
      vv[i] = 1'b1; xv[i] = 1000; cv[i] = 9;
    end
    run_seq(20, "R1");
    do_reset("R1");
    for (int i = 0; i < 30; i++) begin
      vv[i] = 1'b1; xv[i] = (i == 0) ? -1800 : 0; cv[i] = 0;
    end
    run_seq(30, "R1");
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_codes();
    t_default_codes();
    t_sel_switch();
    t_gaps();
    t_saturate();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule